// File: doc/BRIEF.md
# Triple watchdog timer controller

This block provides three independent watchdog channels behind a small memory-mapped register bus. Each channel owns a down-counter and a limit register and reports a running and an expired flag. A shared prescaler divides the system clock into a one-cycle tick, ten per second by default. Each running channel decrements its counter once per tick. When the count runs out, the channel stops and latches its expired flag.

Software starts or restarts a channel by writing its limit register. To keep a channel alive, software reads the channel's counter register. That read returns the current count and reloads the counter from the limit. Channel 0 drives a level interrupt when it expires. Channel 1 drives a pulse on a CPU-only reset output, and channel 2 drives a pulse on a board-wide reset output. A shared mask register can suppress each of these actions. A masked channel still counts and still sets its expired flag.

The sixteen-bit registers are byte-swapped on the bus. Byte-wide registers use the low lane.

Top module: `wdt3_ctrl`

## Requirements
- R1: A running channel decrements its counter by one on every prescaler tick. A tick occurs on every DIV-th clock edge after reset release, where DIV = CLK_HZ / TICK_HZ. On the tick that finds the count at 1 or 0, the channel sets the count to 0, clears its running flag and sets its expired flag. A limit write of V therefore leads to expiry after max(V,1) ticks, provided no reload intervenes.
- R2: A write to offset 0x4 of a channel window loads the value into both the limit and the counter, sets running and clears expired. This also applies while the channel is already running. The write takes priority over a tick in the same cycle.
- R3: A read of offset 0x0 of a channel window returns the count as it was before the access. The read then reloads the counter from the limit and leaves the running and expired flags unchanged. It takes priority over a tick in the same cycle. A read of offset 0x4 returns the limit and changes nothing.
- R4: A read of offset 0x8 of a channel window returns running in bit 0 and expired in bit 1; all other bits are zero. Writes to offsets 0x0 and 0x8 are ignored.
- R5: After reset, every counter and every limit hold 1, all running and expired flags are 0, the mask is 0, and irq, cpu_rst and board_rst are low.
- R6: irq is high exactly while channel 0 is expired and mask bit 0 is 0. It stays high until a limit write to channel 0.
- R7: When channel 1 expires with mask bit 1 at 0, cpu_rst goes high after that clock edge for RST_PULSE cycles. Channel 2 drives board_rst in the same way, gated by mask bit 2.
- R8: Offset 0x30 holds the mask. Bits 2:0 are written from wdata[2:0] and read back in rdata[2:0], with all other bits reading as zero. A mask bit of 1 suppresses only that channel's output action; the channel keeps counting and still sets its expired flag.
- R9: A 16-bit register value V appears on the bus as {V[7:0], V[15:8]} for both reads and writes. Byte registers use the lane wdata[7:0] and rdata[7:0].
- R10: Channel windows sit at 0x00, 0x10 and 0x20. rdata is registered and is valid after the clock edge that samples a read. rdata is zero after any other access, after an idle cycle and after a read of an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte address of the register |
| wdata | input | 16 | Write data, byte-swapped for 16-bit registers |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Channel 0 expiry interrupt level |
| cpu_rst | output | 1 | Channel 1 expiry reset pulse |
| board_rst | output | 1 | Channel 2 expiry reset pulse |

## Verification
Every result of this block is due one clock edge after its cause:
- Read data appears after the edge that samples the read.
- The expired flag and irq change after the edge that carries the final tick or the limit write.
- A reset pulse starts after the expiry edge and lasts RST_PULSE cycles.

The bench drives inputs on falling edges. It keeps a reference model that it advances on each rising edge from the sampled inputs, and it compares all four outputs on the next falling edge. Prescaler ticks fall every fourth edge in the bench, so random limit values of a few ticks exercise expiry, reload-against-tick collisions and mask changes around expiry.

// File: rtl/wdt3_pkg.sv
package wdt3_pkg;
   localparam logic [3:0] OFF_CNT = 4'h0;
   localparam logic [3:0] OFF_LIM = 4'h4;
   localparam logic [3:0] OFF_STS = 4'h8;
   localparam logic [1:0] MASK_WIN = 2'd3;
   localparam int NCH = 3;

   function automatic logic [15:0] lane_swap(input logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction
endpackage

// File: rtl/wdt3_prescale.sv
module wdt3_prescale #(
   parameter int DIV = 5000000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("wdt3_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         assign tick = rst_n;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pc <= '0;
            else if (pc == LAST) pc <= '0;
            else                 pc <= pc + 1'b1;
         end
         assign tick = (pc == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdt3_chan.sv
module wdt3_chan #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic          reload,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] lim,
   output logic          run,
   output logic          expd,
   output logic          fire
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic step;
   assign step = tick && run && !ld && !reload;
   assign fire = step && (cnt <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= ONE;
         lim  <= ONE;
         run  <= 1'b0;
         expd <= 1'b0;
      end else if (ld) begin
         cnt  <= ld_val;
         lim  <= ld_val;
         run  <= 1'b1;
         expd <= 1'b0;
      end else if (reload) begin
         cnt <= lim;
      end else if (fire) begin
         cnt  <= '0;
         run  <= 1'b0;
         expd <= 1'b1;
      end else if (step) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/wdt3_pulse.sv
module wdt3_pulse #(
   parameter int W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse
);
   localparam int PW = $clog2(W + 1);
   localparam logic [PW-1:0] LOADV = PW'(W);

   generate
      if (W < 1) begin : g_bad
         $error("wdt3_pulse: W must be at least 1");
      end
   endgenerate

   logic [PW-1:0] left;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          left <= '0;
      else if (trig)       left <= LOADV;
      else if (left != '0) left <= left - 1'b1;
   end
   assign pulse = (left != '0);
endmodule

// File: rtl/wdt3_ctrl.sv
module wdt3_ctrl #(
   parameter int CW        = 16,
   parameter int CLK_HZ    = 50000000,
   parameter int TICK_HZ   = 10,
   parameter int RST_PULSE = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic        we,
   input  logic [5:0]  addr,
   input  logic [15:0] wdata,
   output logic [15:0] rdata,
   output logic        irq,
   output logic        cpu_rst,
   output logic        board_rst
);
   import wdt3_pkg::*;

   localparam int DIV = CLK_HZ / TICK_HZ;

   generate
      if (CW < 2 || CW > 16) begin : g_bad_cw
         $error("wdt3_ctrl: CW must lie in 2..16");
      end
      if (DIV < 1) begin : g_bad_div
         $error("wdt3_ctrl: CLK_HZ must be at least TICK_HZ");
      end
   endgenerate

   logic [1:0] win;
   logic [3:0] off;
   logic       wr_hit, rd_hit, tick;
   logic [CW-1:0] ld_val;
   logic [NCH-1:0][CW-1:0] cnt_q, lim_q;
   logic [NCH-1:0] run_q, exp_q, fire, ld, reload;
   logic [NCH-1:0] mask_q;
   logic [NCH-1:0] act;

   assign win    = addr[5:4];
   assign off    = addr[3:0];
   assign wr_hit = req && we;
   assign rd_hit = req && !we;
   assign ld_val = CW'(lane_swap(wdata));

   wdt3_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

   for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
      assign ld[gi]     = wr_hit && (win == 2'(gi)) && (off == OFF_LIM);
      assign reload[gi] = rd_hit && (win == 2'(gi)) && (off == OFF_CNT);
      assign act[gi]    = fire[gi] && !mask_q[gi];
      wdt3_chan #(.CW(CW)) u_chan (
         .clk(clk), .rst_n(rst_n), .tick(tick),
         .ld(ld[gi]), .ld_val(ld_val), .reload(reload[gi]),
         .cnt(cnt_q[gi]), .lim(lim_q[gi]),
         .run(run_q[gi]), .expd(exp_q[gi]), .fire(fire[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (wr_hit && win == MASK_WIN && off == OFF_CNT)
         mask_q <= wdata[NCH-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         rdata <= '0;
         if (rd_hit) begin
            if (win == MASK_WIN) begin
               if (off == OFF_CNT) rdata <= 16'(mask_q);
            end else begin
               unique case (off)
                  OFF_CNT: rdata <= lane_swap(16'(cnt_q[win]));
                  OFF_LIM: rdata <= lane_swap(16'(lim_q[win]));
                  OFF_STS: rdata <= {14'd0, exp_q[win], run_q[win]};
                  default: rdata <= '0;
               endcase
            end
         end
      end
   end

   assign irq = exp_q[0] && !mask_q[0];

   wdt3_pulse #(.W(RST_PULSE)) u_cpu (
      .clk(clk), .rst_n(rst_n), .trig(act[1]), .pulse(cpu_rst));
   wdt3_pulse #(.W(RST_PULSE)) u_brd (
      .clk(clk), .rst_n(rst_n), .trig(act[2]), .pulse(board_rst));

   logic unused_act0;
   assign unused_act0 = act[0];
endmodule

// File: rtl/wdt3_ctrl_chk.sv
module wdt3_ctrl_chk #(
   parameter int CW = 16,
   parameter int PW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [2:0][CW-1:0]   cnt,
   input logic [2:0][CW-1:0]   lim,
   input logic [2:0]           run,
   input logic [2:0]           expd,
   input logic [2:0]           mask,
   input logic [2:0]           ld,
   input logic                 irq,
   input logic                 cpu_rst,
   input logic                 board_rst
);
   for (genvar gi = 0; gi < 3; gi++) begin : g_c
      AST_RUN_EXP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         !(run[gi] && expd[gi])); // R4
      AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
         cnt[gi] <= lim[gi]); // R1
      AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
         ld[gi] |=> (run[gi] && !expd[gi])); // R2
   end

   AST_IRQ_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !run[0]); // R6
   AST_CPU_RST_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst) |-> !$past(mask[1])); // R7
   AST_BOARD_RST_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(board_rst) |-> (expd[2] && !$past(mask[2]))); // R7

   generate
      if (PW > 1) begin : g_w
         AST_CPU_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cpu_rst) |=> cpu_rst); // R7
      end
   endgenerate
endmodule

bind wdt3_ctrl wdt3_ctrl_chk #(.CW(CW), .PW(RST_PULSE)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .lim(lim_q), .run(run_q),
   .expd(exp_q), .mask(mask_q), .ld(ld), .irq(irq),
   .cpu_rst(cpu_rst), .board_rst(board_rst)
);

// File: tb/wdt3_ctrl_test.sv
module wdt3_ctrl_test;
   localparam int CLK_HZ = 40, TICK_HZ = 10, PW = 3;
   localparam int DIV = CLK_HZ / TICK_HZ;

   logic clk = 0, rst_n = 0, req = 0, we = 0;
   logic [5:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic irq, cpu_rst, board_rst;

   int total = 0, bad = 0;
   bit done = 0;

   wdt3_ctrl #(.CW(16), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .RST_PULSE(PW)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq), .cpu_rst(cpu_rst), .board_rst(board_rst));

   always #5 clk = ~clk;

   function automatic logic [15:0] sw(input logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction

   // reference model
   int m_pc;
   logic [15:0] m_cnt[3], m_lim[3];
   logic m_run[3], m_exp[3];
   logic [2:0] m_mask;
   int m_pw[3];
   logic [15:0] m_rd;
   string m_tag = "R10";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_mask = 0; m_rd = 0; m_tag = "R10";
         for (int i = 0; i < 3; i++) begin
            m_cnt[i] = 1; m_lim[i] = 1; m_run[i] = 0; m_exp[i] = 0; m_pw[i] = 0;
         end
      end else begin
         logic t;
         logic [1:0] w;
         logic [3:0] o;
         logic ev[3];
         logic [15:0] r;
         w = addr[5:4]; o = addr[3:0]; r = 0;
         t = (m_pc == DIV - 1);
         m_pc = t ? 0 : m_pc + 1;
         m_tag = "R10";
         if (req && !we) begin
            if (w == 3) begin
               if (o == 0) begin r = {13'd0, m_mask}; m_tag = "R8"; end
            end else if (o == 0) begin r = sw(m_cnt[w]); m_tag = "R1 R3 R9"; end
            else if (o == 4) begin r = sw(m_lim[w]); m_tag = "R2 R9"; end
            else if (o == 8) begin r = {14'd0, m_exp[w], m_run[w]}; m_tag = "R4"; end
         end
         for (int i = 0; i < 3; i++) begin
            ev[i] = 0;
            if (req && we && w == i && o == 4) begin
               m_lim[i] = sw(wdata); m_cnt[i] = m_lim[i]; m_run[i] = 1; m_exp[i] = 0;
            end else if (req && !we && w == i && o == 0) begin
               m_cnt[i] = m_lim[i];
            end else if (t && m_run[i]) begin
               if (m_cnt[i] <= 1) begin
                  m_cnt[i] = 0; m_run[i] = 0; m_exp[i] = 1; ev[i] = 1;
               end else m_cnt[i] = m_cnt[i] - 1;
            end
         end
         for (int j = 1; j < 3; j++) begin
            if (ev[j] && !m_mask[j]) m_pw[j] = PW;
            else if (m_pw[j] > 0) m_pw[j] = m_pw[j] - 1;
         end
         if (req && we && w == 3 && o == 0) m_mask = wdata[2:0];
         m_rd = r;
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6 irq", 16'(irq), 16'(m_exp[0] && !m_mask[0]));
         chk("R7 cpu_rst", 16'(cpu_rst), 16'(m_pw[1] > 0));
         chk("R7 board_rst", 16'(board_rst), 16'(m_pw[2] > 0));
         chk(m_tag, rdata, m_rd);
      end
   end

   task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
      @(negedge clk); req = 0; we = 0;
   endtask

   task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
      @(negedge clk); req = 1; we = 0; addr = a;
      @(negedge clk); req = 0; d = rdata;
   endtask

   task automatic finish_run;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R5 irq in reset", 16'(irq), 16'd0);
      chk("R5 cpu_rst in reset", 16'(cpu_rst), 16'd0);
      rst_n = 1;
      // R5 reset values
      bus_rd(6'h24, d); chk("R5 limit ch2", d, 16'h0100);
      bus_rd(6'h00, d); chk("R5 counter ch0", d, 16'h0100);
      bus_rd(6'h18, d); chk("R5 status ch1", d, 16'h0000);
      bus_rd(6'h30, d); chk("R5 mask", d, 16'h0000);
      chk("R5 board_rst", 16'(board_rst), 16'd0);
      // R9 swapped halfword
      bus_wr(6'h14, 16'h3412);
      bus_rd(6'h14, d); chk("R9 limit swap", d, 16'h3412);
      // R4 status write ignored
      bus_wr(6'h18, 16'h0000);
      bus_rd(6'h18, d); chk("R4 status after write", d, 16'h0001);
      // R8 mask bits 7:3 dropped, masked channel still expires
      bus_wr(6'h30, 16'h00FA);
      bus_rd(6'h30, d); chk("R8 mask readback", d, 16'h0002);
      bus_wr(6'h14, 16'h0200);
      repeat (4 * DIV) @(negedge clk);
      chk("R8 masked no pulse", 16'(cpu_rst), 16'd0);
      bus_rd(6'h18, d); chk("R8 masked status expired", d, 16'h0002);
      bus_wr(6'h30, 16'h0000);
      // R6 irq after channel 0 expiry, cleared by limit write
      bus_wr(6'h04, 16'h0100);
      repeat (2 * DIV) @(negedge clk);
      chk("R6 irq set", 16'(irq), 16'd1);
      bus_wr(6'h04, 16'h0900);
      chk("R6 irq cleared", 16'(irq), 16'd0);
      // R10 unmapped offset
      bus_rd(6'h0C, d); chk("R10 unmapped", d, 16'h0000);
      // random mix
      for (int n = 0; n < 2500; n++) begin
         int k;
         logic [1:0] w;
         logic [5:0] a;
         k = $urandom_range(0, 9);
         w = 2'($urandom_range(0, 2));
         case (k)
            0, 1: bus_wr({w, 4'h4}, sw(16'($urandom_range(0, 7))));
            2:    bus_wr({w, 4'h4}, sw(16'($urandom_range(0, 40))));
            3, 4: bus_rd({w, 4'h0}, d);
            5:    bus_rd({w, 4'h8}, d);
            6:    bus_rd({w, 4'h4}, d);
            7:    bus_wr(6'h30, 16'($urandom_range(0, 255)));
            8:    begin a = 6'($urandom_range(0, 63)); bus_wr(a, 16'($urandom)); end
            default: begin a = 6'($urandom_range(0, 63)); bus_rd(a, d); end
         endcase
         repeat ($urandom_range(0, 3)) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule